// File: doc/BRIEF.md
# Packed Horizontal Pair Add/Subtract Unit

This unit takes two 128-bit operand vectors and reduces neighbouring element pairs inside each operand to single values, then packs those values into one 128-bit result. Each operation either adds the two members of a pair or subtracts the upper member from the lower one. Elements are 16 or 32 bits wide.

With 16-bit elements the arithmetic either wraps or clamps to the signed 16-bit range. With 32-bit elements the arithmetic always wraps. The unit accepts one operation per cycle on a valid strobe. It returns the result from a register one cycle later, together with a matching valid. It suits a vector execution stage that needs pairwise reductions, such as partial sums across a row.

Top module: `hpair_unit`

## Requirements
- R1: Element j of the vector formed as {b_i, a_i} is taken at bits [W*j +: W], where W is the element width and a_i is the low half. Result slot k is formed from elements 2k and 2k+1 of that vector. With sub_i=0 the slot holds their sum.
- R2: Results from pairs of a_i fill the lower half of result_o in ascending pair order. Results from pairs of b_i fill the upper half.
- R3: With sub_i=1, each slot holds element 2k minus element 2k+1. For example, the pair (1, 2) gives -1 and the pair (4, 128) gives -124.
- R4: With wide_i=0 and sat_i=1, a sum or difference above 32767 gives 0x7FFF. Examples: 32767+1, and 32767-(-1).
- R5: With wide_i=0 and sat_i=1, a sum or difference below -32768 gives 0x8000. Examples: -32768+(-1), and -32768-1.
- R6: With wide_i=1, each operand holds four 32-bit elements. Slots 0..1 of result_o come from a_i and slots 2..3 come from b_i.
- R7: With sat_i=0, results wrap modulo 2^16 (wide_i=0) or modulo 2^32 (wide_i=1). For example, 0x7FFF+1 gives 0x8000.
- R8: With wide_i=1, sat_i has no effect. For example, 0x7FFFFFFF+1 gives 0x80000000 even when sat_i=1.
- R9: valid_o is valid_i delayed by one clock. result_o shows the operation accepted at the previous rising edge.
- R10: result_o keeps its value in any cycle that follows a cycle with valid_i low, whatever the operand inputs do.
- R11: While rst_ni is low, valid_o is 0 and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| a_i | input | 128 | Operand A |
| b_i | input | 128 | Operand B |
| sub_i | input | 1 | 1 = subtract (even minus odd), 0 = add |
| wide_i | input | 1 | 1 = 32-bit elements, 0 = 16-bit elements |
| sat_i | input | 1 | Signed saturation for 16-bit elements |
| valid_o | output | 1 | Result valid |
| result_o | output | 128 | Packed result |

## Verification
The latency and hold properties take for granted that valid_i is low during reset and that the control inputs are sampled only on cycles where valid_i is high. The bench therefore holds valid_i low until after reset is released. Between operations it drives random operands and random control bits with valid_i low. The immediate clamp checks rely on sub_i and sat_i being stable and known whenever operands change, and the bench always drives them as known values.

// File: rtl/hpair_pkg.sv
package hpair_pkg;
  localparam int NARROW_W = 16;
  localparam int WIDE_W   = 32;
endpackage

// File: rtl/hpair_alu.sv
module hpair_alu #(
  parameter int W       = 16,
  parameter bit HAS_SAT = 1'b1
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  input  logic         sat_i,
  output logic [W-1:0] res_o
);
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ext_x, ext_y, full;
  logic       ovf, sat_en;

  assign ext_x = {x_i[W-1], x_i};
  assign ext_y = {y_i[W-1], y_i};
  assign full  = sub_i ? (ext_x - ext_y) : (ext_x + ext_y);
  assign ovf   = full[W] ^ full[W-1];

  generate
    if (HAS_SAT) begin : g_sat
      assign sat_en = sat_i;
    end else begin : g_wrap
      assign sat_en = 1'b0 & sat_i;
    end
  endgenerate

  always_comb begin
    if (sat_en && ovf) res_o = full[W] ? MIN_V : MAX_V;
    else               res_o = full[W-1:0];
  end

  always_comb begin
    if (HAS_SAT && sat_i && !sub_i && !x_i[W-1] && !y_i[W-1])
      p_sat_hi_r4: assert (!res_o[W-1]);
    if (HAS_SAT && sat_i && !sub_i && x_i[W-1] && y_i[W-1])
      p_sat_lo_r5: assert (res_o[W-1]);
    if (sub_i && y_i == '0)
      p_sub_zero_r3: assert (res_o == x_i);
  end
endmodule

// File: rtl/hpair_unit.sv
module hpair_unit
  import hpair_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              wide_i,
  input  logic              sat_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int N_NARROW = DATA_W / NARROW_W;
  localparam int N_WIDE   = DATA_W / WIDE_W;

  logic [2*DATA_W-1:0] cat;
  logic [DATA_W-1:0]   res_n, res_w, res_nxt;

  assign cat = {b_i, a_i};

  // slot k takes elements 2k and 2k+1 of {b,a}: A pairs land low, B pairs high
  for (genvar g = 0; g < N_NARROW; g++) begin : g_narrow
    hpair_alu #(.W(NARROW_W), .HAS_SAT(1'b1)) u_alu (
      .x_i  (cat[2*NARROW_W*g +: NARROW_W]),
      .y_i  (cat[2*NARROW_W*g + NARROW_W +: NARROW_W]),
      .sub_i(sub_i),
      .sat_i(sat_i),
      .res_o(res_n[NARROW_W*g +: NARROW_W])
    );
  end

  for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
    hpair_alu #(.W(WIDE_W), .HAS_SAT(1'b0)) u_alu (
      .x_i  (cat[2*WIDE_W*g +: WIDE_W]),
      .y_i  (cat[2*WIDE_W*g + WIDE_W +: WIDE_W]),
      .sub_i(sub_i),
      .sat_i(sat_i),
      .res_o(res_w[WIDE_W*g +: WIDE_W])
    );
  end

  assign res_nxt = wide_i ? res_w : res_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_nxt;
    end
  end

  p_valid_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
endmodule

// File: tb/hpair_unit_tb_top.sv
`timescale 1ns/1ps
module hpair_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] a_i = '0, b_i = '0;
  logic         sub_i = 1'b0, wide_i = 1'b0, sat_i = 1'b0;
  logic         valid_o;
  logic [127:0] result_o;

  int n_checks = 0, n_err = 0;
  bit done = 1'b0;
  logic [127:0] exp_q[$];
  string        tag_q[$];
  logic [127:0] last_res = '0;

  always #2.5 clk = ~clk;

  hpair_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .sub_i(sub_i), .wide_i(wide_i), .sat_i(sat_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b,
                                         bit sub, bit wide, bit sat);
    logic [255:0] s;
    logic [127:0] o;
    s = {b, a};
    o = '0;
    if (!wide) begin
      for (int j = 0; j < 8; j++) begin
        longint x, y, r;
        x = longint'($signed(s[32*j +: 16]));
        y = longint'($signed(s[32*j+16 +: 16]));
        r = sub ? x - y : x + y;
        if (sat && r > 32767)  r = 32767;
        if (sat && r < -32768) r = -32768;
        o[16*j +: 16] = r[15:0];
      end
    end else begin
      for (int j = 0; j < 4; j++) begin
        longint x, y, r;
        x = longint'($signed(s[64*j +: 32]));
        y = longint'($signed(s[64*j+32 +: 32]));
        r = sub ? x - y : x + y;
        o[32*j +: 32] = r[31:0];
      end
    end
    return o;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: one operation, then one idle cycle with random garbage
  task automatic send(logic [127:0] a, logic [127:0] b, bit sub, bit wide,
                      bit sat, string tag);
    @(negedge clk);
    a_i = a; b_i = b; sub_i = sub; wide_i = wide; sat_i = sat; valid_i = 1'b1;
    exp_q.push_back(model(a, b, sub, wide, sat));
    tag_q.push_back(tag);
    @(negedge clk);
    valid_i = 1'b0;
    a_i = rnd128(); b_i = rnd128();
    sub_i = 1'($urandom); wide_i = 1'($urandom); sat_i = 1'($urandom);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected valid_o", result_o, '0);
        end else begin
          logic [127:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(result_o === e, t, result_o, e);
        end
        last_res = result_o;
      end else begin
        check(result_o === last_res, "R10 hold while idle", result_o, last_res);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_err++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [127:0] va, vb;
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0 && result_o === '0, "R11 reset state",
          {127'd0, valid_o} | result_o, '0);
    rst_n = 1'b1;
    @(negedge clk);

    va = {16'd8, 16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1};
    vb = {16'd19, 16'd6, 16'd12, 16'd24, 16'd3, 16'd4, 16'd128, 16'd4};
    send(va, vb, 0, 0, 0, "R1 R2 pair add 16b");
    send(va, vb, 1, 0, 0, "R3 pair sub 16b");
    send(va, '0, 0, 0, 0, "R2 A low B high");
    send('0, vb, 1, 0, 1, "R2 B pairs to upper half");

    vb = {16'hFFFF, 16'h8000, 16'h0001, 16'h7FFF, 16'd3, 16'd4, 16'd128, 16'd4};
    send(va, vb, 0, 0, 1, "R4 R5 saturating add");
    vb = {16'h0001, 16'h8000, 16'hFFFF, 16'h7FFF, 16'd3, 16'd4, 16'd128, 16'd4};
    send(va, vb, 1, 0, 1, "R4 R5 saturating sub");
    va = {16'h0001, 16'h7FFF, 16'hFFFF, 16'h8000, 16'h0001, 16'h7FFF, 16'h0, 16'h0};
    send(va, va, 0, 0, 0, "R7 16b wrap");

    va = {32'd4, 32'd3, 32'd2, 32'd1};
    vb = {32'd3, 32'd4, 32'd128, 32'd4};
    send(va, vb, 0, 1, 0, "R6 32b add");
    send(va, vb, 1, 1, 0, "R6 32b sub");
    va = {32'h8000_0000, 32'hFFFF_FFFF, 32'd1, 32'h7FFF_FFFF};
    send(va, va, 0, 1, 1, "R8 sat ignored 32b");
    send(va, va, 1, 1, 0, "R7 32b wrap sub");

    // back-to-back: valid every cycle
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      a_i = rnd128(); b_i = rnd128();
      sub_i = 1'($urandom); wide_i = 1'($urandom); sat_i = 1'($urandom);
      valid_i = 1'b1;
      exp_q.push_back(model(a_i, b_i, sub_i, wide_i, sat_i));
      tag_q.push_back("R9 back-to-back random");
    end
    @(negedge clk);
    valid_i = 1'b0;

    for (int i = 0; i < 60; i++)
      send(rnd128(), rnd128(), 1'($urandom), 1'($urandom), 1'($urandom),
           "R1 random");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 all results returned",
          128'(exp_q.size()), '0);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule